// File: doc/BRIEF.md
# Non-Preemptive Bus Arbiter with Enable Dead Time

This block decides which of several masters may drive a shared bus. It produces one driver-enable output per master. A master that gets the bus keeps it for as long as it holds its request, and no other request can take the bus away. When the owner drops its request, the arbiter chooses the next master in that same cycle.

Two selection policies are available. In fixed-priority mode the lowest-numbered requester wins. In round-robin mode the search starts just after the most recent owner, so the arbiter remembers whose turn is next even while the bus is idle. The policy input is only taken while the arbiter is idle; a choice made at a handover uses the policy captured in the last idle cycle.

Whenever a new enable would rise, the arbiter first ensures that all enables have been low for at least `DEAD_CYCLES` whole clock cycles. This covers the time the outgoing driver needs to turn off. If the chosen master withdraws during that wait, its enable is never raised and the arbiter goes back to idle.

Top module: `bus_arbiter_dt`

## Requirements
- R1: While rst_ni is low, every bit of en_o is 0 and the arbiter is idle. Right after reset the bus counts as having been quiet for the full dead time, and the round-robin pointer starts at requester 0.
- R2: At most one bit of en_o is 1 in any cycle.
- R3: While the owner's req_i bit stays 1, en_o keeps the same single bit set, whatever the other requests do.
- R4: In fixed-priority mode (rr_mode_i = 0), the requester with the lowest index wins among those requesting.
- R5: In round-robin mode (rr_mode_i = 1), the search starts at the index after the most recent owner, wrapping from NUM_REQ-1 to 0, and takes the first requester found.
- R6: When the owner drops its request, the next winner is chosen from the requests present in that same cycle. With DEAD_CYCLES = 0 the new enable is set in the very next cycle.
- R7: A bit of en_o rises only after all bits of en_o have been 0 for at least DEAD_CYCLES consecutive cycles. For a handover with DEAD_CYCLES = D > 0, exactly D all-low cycles come between the old and the new enable.
- R8: If the chosen requester drops its request during the dead-time wait, its enable never rises and the arbiter returns to idle.
- R9: rr_mode_i is sampled only while idle. A handover decision uses the mode captured in the last idle cycle.
- R10: When the bus has been quiet long enough, a request made while idle gets its enable in the next cycle.
- R11: In the cycle after the owner drops its request, that owner's enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rr_mode_i | input | 1 | 1 = round-robin, 0 = fixed priority; sampled only when idle |
| req_i | input | NUM_REQ | Bus request, one bit per master |
| en_o | output | NUM_REQ | Bus driver enable, one bit per master, at most one set |

## Verification
The hardest case to reach from the ports is a decision that depends on the latched mode. With two masters, both policies pick the same master at a handover, so the bench uses three masters. It latches round-robin while idle, then switches the input to fixed priority during an ownership and releases. The result must differ from what fixed priority would pick. Withdrawal inside the dead-time window is reached by releasing the bus while a second master is waiting, then dropping that master's request one cycle later.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_GAP  = 2'd1,
    PH_HOLD = 2'd2
  } phase_e;
endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int unsigned NUM_REQ = 2,
  parameter int unsigned IW      = 1
) (
  input  logic [NUM_REQ-1:0] req_i,
  input  logic [IW-1:0]      turn_i,
  input  logic               rr_i,
  output logic               any_o,
  output logic [IW-1:0]      idx_o
);
  function automatic int slot(input int k, input logic rr, input logic [IW-1:0] turn);
    int p;
    p = rr ? int'(turn) + k : k;
    if (p >= int'(NUM_REQ)) p = p - int'(NUM_REQ);
    return p;
  endfunction

  assign any_o = |req_i;

  // scan from the farthest slot down so the nearest requester overwrites
  always_comb begin
    idx_o = '0;
    for (int k = int'(NUM_REQ) - 1; k >= 0; k--) begin
      if (req_i[slot(k, rr_i, turn_i)]) idx_o = IW'(slot(k, rr_i, turn_i));
    end
  end
endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int unsigned DEAD_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic ready_o
);
  generate
    if (DEAD_CYCLES == 0) begin : g_nogap
      logic unused_tie;
      assign unused_tie = ^{clk_i, rst_ni, busy_i};
      assign ready_o    = 1'b1;
    end else begin : g_gap
      localparam int unsigned CW = $clog2(DEAD_CYCLES + 1);
      logic [CW-1:0] cnt_q;

      // counts completed quiet cycles, saturating at DEAD_CYCLES
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         cnt_q <= CW'(DEAD_CYCLES);
        else if (busy_i)                     cnt_q <= '0;
        else if (cnt_q != CW'(DEAD_CYCLES))  cnt_q <= cnt_q + CW'(1);
      end

      // true when the next cycle may carry a fresh enable
      assign ready_o = !busy_i && (int'(cnt_q) + 1 >= int'(DEAD_CYCLES));
    end
  endgenerate
endmodule

// File: rtl/bus_arbiter_dt.sv
module bus_arbiter_dt
  import bus_arb_pkg::*;
#(
  parameter int unsigned NUM_REQ     = 2,
  parameter int unsigned DEAD_CYCLES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rr_mode_i,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-1:0] en_o
);
  localparam int unsigned IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  phase_e        phase_q, phase_d;
  logic [IW-1:0] owner_q, owner_d;
  logic [IW-1:0] turn_q, turn_d;
  logic          mode_q, mode_d;
  logic [IW-1:0] win;
  logic          any_req, gap_ok, bus_busy, rr_sel;

  function automatic logic [IW-1:0] after(input logic [IW-1:0] i);
    if (int'(i) == int'(NUM_REQ) - 1) return '0;
    return i + IW'(1);
  endfunction

  always_comb begin
    en_o = '0;
    if (phase_q == PH_HOLD) en_o[owner_q] = 1'b1;
  end

  assign bus_busy = |en_o;
  assign rr_sel   = (phase_q == PH_IDLE) ? rr_mode_i : mode_q;

  arb_pick #(.NUM_REQ(NUM_REQ), .IW(IW)) u_pick (
    .req_i  (req_i),
    .turn_i (turn_q),
    .rr_i   (rr_sel),
    .any_o  (any_req),
    .idx_o  (win)
  );

  gap_timer #(.DEAD_CYCLES(DEAD_CYCLES)) u_gap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (bus_busy),
    .ready_o (gap_ok)
  );

  always_comb begin
    phase_d = phase_q;
    owner_d = owner_q;
    turn_d  = turn_q;
    mode_d  = mode_q;
    unique case (phase_q)
      PH_IDLE: begin
        mode_d = rr_mode_i;
        if (any_req) begin
          owner_d = win;
          if (gap_ok) begin
            phase_d = PH_HOLD;
            turn_d  = after(win);
          end else begin
            phase_d = PH_GAP;
          end
        end
      end
      PH_HOLD: begin
        // owner released: re-arbitrate in the same cycle
        if (!req_i[owner_q]) begin
          if (any_req) begin
            owner_d = win;
            if (gap_ok) begin
              phase_d = PH_HOLD;
              turn_d  = after(win);
            end else begin
              phase_d = PH_GAP;
            end
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      PH_GAP: begin
        if (!req_i[owner_q]) begin
          phase_d = PH_IDLE;
        end else if (gap_ok) begin
          phase_d = PH_HOLD;
          turn_d  = after(owner_q);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      owner_q <= '0;
      turn_q  <= '0;
      mode_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      owner_q <= owner_d;
      turn_q  <= turn_d;
      mode_q  <= mode_d;
    end
  end
endmodule

// File: rtl/bus_arbiter_dt_chk.sv
module bus_arbiter_dt_chk #(
  parameter int unsigned NUM_REQ     = 2,
  parameter int unsigned DEAD_CYCLES = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_REQ-1:0] req_i,
  input logic [NUM_REQ-1:0] en_o
);
  logic [NUM_REQ-1:0] prev_en, prev_req;
  int unsigned        quiet_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_en  <= '0;
      prev_req <= '0;
      quiet_q  <= DEAD_CYCLES;
    end else begin
      prev_en  <= en_o;
      prev_req <= req_i;
      if (|en_o)                      quiet_q <= 0;
      else if (quiet_q < DEAD_CYCLES) quiet_q <= quiet_q + 1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) !rst_ni |-> (en_o == '0));

  // R2
  mutex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(en_o));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_o & req_i) != '0) |=> (en_o == $past(en_o)));

  // R11
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_o != '0) && ((en_o & req_i) == '0)) |=> ((en_o & $past(en_o)) == '0));

  // R7
  dead_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_o & ~prev_en) != '0) |-> (quiet_q >= DEAD_CYCLES));

  // R8
  grant_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_o & ~prev_en & ~prev_req) == '0));
endmodule

bind bus_arbiter_dt bus_arbiter_dt_chk #(
  .NUM_REQ     (NUM_REQ),
  .DEAD_CYCLES (DEAD_CYCLES)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .en_o   (en_o)
);

// File: tb/tb_bus_arbiter_dt.sv
module tb_bus_arbiter_dt;
  localparam int N          = 3;
  localparam int DEAD       = 2;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         rr_mode_i;
  logic [N-1:0] req_i;
  logic [N-1:0] en_o;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 0;

  // behavioural reference state
  int own = -1, pend = -1, quiet = DEAD, nxt = 0;
  bit mode_l = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bus_arbiter_dt #(.NUM_REQ(N), .DEAD_CYCLES(DEAD)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rr_mode_i(rr_mode_i), .req_i(req_i), .en_o(en_o)
  );

  function automatic int choose(bit m, logic [N-1:0] r, int start);
    for (int k = 0; k < N; k++) begin
      int p;
      p = m ? (start + k) % N : k;
      if (r[p]) return p;
    end
    return -1;
  endfunction

  task automatic begin_grant(int w, int nq);
    if (nq >= DEAD) begin own = w; nxt = (w + 1) % N; end
    else pend = w;
  endtask

  task automatic model_edge();
    int nq, w;
    nq = (own >= 0) ? 0 : ((quiet + 1 > DEAD) ? DEAD : quiet + 1);
    if (own >= 0) begin
      if (!req_i[own]) begin
        w = choose(mode_l, req_i, nxt);
        own = -1;
        if (w >= 0) begin_grant(w, nq);
      end
    end else if (pend >= 0) begin
      if (!req_i[pend]) pend = -1;
      else if (nq >= DEAD) begin own = pend; nxt = (own + 1) % N; pend = -1; end
    end else begin
      mode_l = rr_mode_i;
      w = choose(rr_mode_i, req_i, nxt);
      if (w >= 0) begin_grant(w, nq);
    end
    quiet = nq;
  endtask

  task automatic check(string tag);
    logic [N-1:0] expv;
    expv = (own >= 0) ? N'(1 << own) : '0;
    vectors++;
    if (en_o !== expv) begin
      miscompares++;
      $display("FAIL %s: en_o=%b expected %b at %0t", tag, en_o, expv, $time);
    end
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      model_edge();
      @(negedge clk_i);
      check(tag);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    miscompares++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; req_i = '0; rr_mode_i = 1'b0;
    repeat (3) @(negedge clk_i);
    req_i = 3'b111;
    @(negedge clk_i);
    check("R1 reset");
    rst_ni = 1'b1; req_i = '0;
    run(2, "R1 idle after reset");

    // fixed priority from idle: R0 wins, then holds against others
    req_i = 3'b011;
    run(1, "R4 R10 fixed priority grant");
    req_i = 3'b111;
    run(3, "R3 non-preemption");
    // release with pending: gap of DEAD cycles, then lowest pending
    req_i = 3'b110;
    run(4, "R6 R7 handover gap");
    req_i = 3'b100;
    run(5, "R6 R7 second handover");
    req_i = 3'b000;
    run(4, "R11 release to idle");

    // mode latched in idle (rr), switched during ownership
    rr_mode_i = 1'b1; req_i = 3'b010;
    run(2, "R10 round-robin idle grant");
    req_i = 3'b111; rr_mode_i = 1'b0;
    run(2, "R9 mode change while owned");
    req_i = 3'b101;
    run(5, "R9 handover uses latched mode");
    req_i = 3'b000;
    run(4, "R11 idle");

    // round-robin turn remembered across idle
    rr_mode_i = 1'b1; req_i = 3'b001;
    run(2, "R5 rr owner 0");
    req_i = 3'b000;
    run(3, "R5 rr idle");
    req_i = 3'b011;
    run(3, "R5 rr next turn after owner 0");
    req_i = 3'b000;
    run(4, "R11 idle");

    // withdrawal during the dead-time wait
    rr_mode_i = 1'b0; req_i = 3'b001;
    run(2, "R10 grant");
    req_i = 3'b011;
    run(1, "R3 hold");
    req_i = 3'b010;
    run(1, "R6 enter gap");
    req_i = 3'b000;
    run(4, "R8 withdraw in gap");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) req_i = N'($urandom_range(0, (1 << N) - 1));
      if ($urandom_range(0, 15) == 0) rr_mode_i = 1'($urandom_range(0, 1));
      run(1, "R2 random traffic");
    end
    finish_run();
  end
endmodule